// File: doc/BRIEF.md
# Serial Chain Configuration Receiver

This block is one link in a chain of serially configured devices. Every device in the chain receives the same configuration clock, and the serial output of each link drives the serial input of the next. The block samples its serial input on rising clock edges. It waits for a fixed start pattern, then reads a length word that gives the number of data bits in the whole chain's bitstream. It keeps the first `OWN_BITS` data bits for itself. Every data bit after those passes through to its serial output, re-timed to change on the falling edge.

The serial output stays high while the block hunts for the start pattern, reads the length word and loads its own bits. When the length word's bit count has been received, the block raises a done flag and stays done until reset. From then on the serial input has no effect. The meaning of the loaded bits is outside this block.

Top module: `cfg_chain_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `ser_out` is 1, `load_done` is 0 and `fwd_mode` is 0.
- R2: The start pattern is `PREAMBLE` (default 8'hB5, its top bit must be 1), received most significant bit first. It is recognised when the last `PRE_W` bits sampled since reset equal it. Any bits that do not complete the pattern are discarded, and the search continues.
- R3: The `LEN_W`-bit (default 24) length word follows the start pattern immediately, most significant bit first. Its value L is the number of data bits that follow it.
- R4: `ser_out` is 1 during the search, during the length word and during the first `OWN_BITS` (default 16) data bits, which the block keeps.
- R5: A data bit with zero-based index i, where `OWN_BITS` <= i < L, appears on `ser_out` from the falling edge that follows the rising edge that sampled it, and holds for one clock period. `fwd_mode` is 1 after the rising edge that samples index `OWN_BITS`-1, and stays 1 until done.
- R6: `load_done` rises at the rising edge that samples data bit L-1. When L = 0 it rises at the edge that samples the last length bit. It stays 1 until reset, while `ser_out` stays 1 and `ser_in` is ignored. `load_done` and `fwd_mode` are never both 1.
- R7: When L <= `OWN_BITS`, no bit is forwarded: `ser_out` stays 1 and `fwd_mode` stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Shared configuration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data from the upstream link |
| ser_out | output | 1 | Serial data to the downstream link; 1 when idle |
| load_done | output | 1 | The full length count has elapsed |
| fwd_mode | output | 1 | Pass-through phase is active |

## Verification
The hardest cases to reach are the boundaries of the length word relative to the device's own share. These are a length of zero, a length just below, at and just above `OWN_BITS`, and a start pattern preceded by a near-miss that shares its prefix. The stimulus reaches each case with a fresh reset and a hand-built stream: a partial pattern broken by one wrong bit, then the real pattern, then a chosen length and data pattern, then trailing bits sent after done. A behavioural model tracks every rising and falling edge. It checks whether each bit was kept, forwarded or ignored, and the exact edge on which it appears at the output.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_LEN, ST_DATA, ST_DONE} chain_st_e;

  // shift one serial bit into a word, most significant bit first
  function automatic logic [31:0] f_push_msb(input logic [31:0] acc, input logic b);
    return {acc[30:0], b};
  endfunction

  // a data bit with this index is forwarded when the own share is used up
  function automatic logic f_is_fwd(input logic [31:0] idx, input logic [31:0] own);
    return idx >= own;
  endfunction
endpackage

// File: rtl/cfg_hdr_sync.sv
module cfg_hdr_sync #(
  parameter int unsigned PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hB5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic bit_in,
  output logic hit
);
  logic [PRE_W-1:0] win;
  logic [PRE_W-1:0] win_nxt;

  assign win_nxt = {win[PRE_W-2:0], bit_in};
  assign hit     = hunt && (win_nxt == PREAMBLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    win <= '0;
    else if (hunt) win <= win_nxt;
  end

  // R2: a recognised pattern ends the search
  p_hit_ends_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hunt)
    else $error("p_hit_ends_hunt_r2");
endmodule

// File: rtl/cfg_load_ctr.sv
module cfg_load_ctr
  import cfgchain_pkg::*;
#(
  parameter int unsigned LEN_W    = 24,
  parameter int unsigned OWN_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic hdr_hit,
  output logic hunt,
  output logic fwd_mode,
  output logic done
);
  localparam int unsigned LC_W = $clog2(LEN_W);

  chain_st_e        st;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt;
  logic [LC_W-1:0]  lcnt;
  logic [LEN_W-1:0] len_nxt;
  logic [LEN_W-1:0] cnt_nxt;
  logic             len_last;

  assign len_nxt  = LEN_W'(f_push_msb(32'(len), bit_in));
  assign cnt_nxt  = cnt + LEN_W'(1);
  assign len_last = (lcnt == LC_W'(LEN_W - 1));
  assign hunt     = (st == ST_HUNT);
  assign done     = (st == ST_DONE);
  assign fwd_mode = (st == ST_DATA) && f_is_fwd(32'(cnt), 32'(OWN_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_HUNT;
      len  <= '0;
      cnt  <= '0;
      lcnt <= '0;
    end else begin
      case (st)
        ST_HUNT: if (hdr_hit) begin
          st   <= ST_LEN;
          lcnt <= '0;
          len  <= '0;
        end
        ST_LEN: begin
          len  <= len_nxt;
          lcnt <= lcnt + LC_W'(1);
          if (len_last) begin
            cnt <= '0;
            st  <= (len_nxt == '0) ? ST_DONE : ST_DATA;
          end
        end
        ST_DATA: begin
          cnt <= cnt_nxt;
          if (cnt_nxt == len) st <= ST_DONE;
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  // R6: done is sticky until reset
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done)
    else $error("p_done_sticky_r6");

  // R6: done and forwarding exclude each other
  p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fwd_mode))
    else $error("p_done_excl_r6");

  // R5: once forwarding starts, it lasts until done
  p_fwd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_mode |=> (fwd_mode || done))
    else $error("p_fwd_hold_r5");
endmodule

// File: rtl/cfg_fwd_retime.sv
module cfg_fwd_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic fwd_en,
  output logic ser_out
);
  logic fwd_vld_q;
  logic fwd_bit_q;

  // capture on the rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_vld_q <= 1'b0;
      fwd_bit_q <= 1'b1;
    end else begin
      fwd_vld_q <= fwd_en;
      fwd_bit_q <= bit_in;
    end
  end

  // launch on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ser_out <= 1'b1;
    else        ser_out <= fwd_vld_q ? fwd_bit_q : 1'b1;
  end

  // R4: no captured bit means an idle-high output
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_vld_q |-> ser_out)
    else $error("p_idle_high_r4");

  // R5: a captured bit is on the output before the next rising edge
  p_copy_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld_q |-> (ser_out == fwd_bit_q))
    else $error("p_copy_out_r5");
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx #(
  parameter int unsigned PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hB5,
  parameter int unsigned LEN_W = 24,
  parameter int unsigned OWN_BITS = 16
) (
  input  logic cfg_clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic ser_out,
  output logic load_done,
  output logic fwd_mode
);
  logic hunt;
  logic hdr_hit;

  cfg_hdr_sync #(.PRE_W(PRE_W), .PREAMBLE(PREAMBLE)) u_sync (
    .clk(cfg_clk), .rst_n(rst_n), .hunt(hunt), .bit_in(ser_in), .hit(hdr_hit)
  );

  cfg_load_ctr #(.LEN_W(LEN_W), .OWN_BITS(OWN_BITS)) u_ctr (
    .clk(cfg_clk), .rst_n(rst_n), .bit_in(ser_in), .hdr_hit(hdr_hit),
    .hunt(hunt), .fwd_mode(fwd_mode), .done(load_done)
  );

  cfg_fwd_retime u_rtm (
    .clk(cfg_clk), .rst_n(rst_n), .bit_in(ser_in), .fwd_en(fwd_mode),
    .ser_out(ser_out)
  );

  // R1: the output is idle while searching
  p_hunt_quiet_r1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    hunt |-> (!load_done && !fwd_mode))
    else $error("p_hunt_quiet_r1");
endmodule

// File: tb/tb_cfg_chain_rx.sv
module tb_cfg_chain_rx;
  localparam int OWN = 16;
  localparam int PRE = 8'hB5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic ser_out, load_done, fwd_mode;
  int checks = 0;
  int errors = 0;

  // behavioural model state
  int m_ph;   // 0 search, 1 length, 2 data, 3 done
  int m_hist, m_len, m_lc, m_idx;
  bit m_fwd, m_fb;
  bit fwd_q[$];

  always #10 clk = ~clk;

  cfg_chain_rx dut (.cfg_clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .ser_out(ser_out), .load_done(load_done), .fwd_mode(fwd_mode));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ph = 0; m_hist = 0; m_len = 0; m_lc = 0; m_idx = 0; m_fwd = 0; m_fb = 1;
    fwd_q.delete();
  endtask

  task automatic model_step(input bit b);
    m_fwd = 0;
    case (m_ph)
      0: begin
        m_hist = ((m_hist << 1) | b) & 8'hFF;
        if (m_hist == PRE) begin m_ph = 1; m_lc = 0; m_len = 0; end
      end
      1: begin
        m_len = (m_len << 1) | b; m_lc++;
        if (m_lc == 24) begin m_idx = 0; m_ph = (m_len == 0) ? 3 : 2; end
      end
      2: begin
        if (m_idx >= OWN) begin m_fwd = 1; fwd_q.push_back(b); end
        m_idx++;
        if (m_idx == m_len) m_ph = 3;
      end
      default: ;
    endcase
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    #35;
    check(ser_out == 1'b1, "R1", ser_out, 1);
    check(load_done == 1'b0, "R1", load_done, 0);
    check(fwd_mode == 1'b0, "R1", fwd_mode, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(ser_out == 1'b1 && !load_done && !fwd_mode, "R1", ser_out, 1);
  endtask

  task automatic send_bit(input bit b);
    string tg;
    bit exp_fm, exp_out;
    ser_in = b;
    @(posedge clk); #1;
    model_step(b);
    exp_fm = (m_ph == 2) && (m_idx >= OWN);
    tg = (m_ph == 0) ? "R2" : (m_ph == 1) ? "R3" : "R5";
    check(fwd_mode == exp_fm, tg, fwd_mode, exp_fm);
    if (m_ph == 3 && m_len <= OWN)
      check(load_done == 1'b1, "R7", load_done, 1);
    else
      check(load_done == (m_ph == 3), "R6", load_done, m_ph == 3);
    @(negedge clk); #1;
    if (m_fwd) begin
      exp_out = fwd_q.pop_front();
      check(ser_out == exp_out, "R5", ser_out, exp_out);
    end else if (m_ph == 3) begin
      check(ser_out == 1'b1, "R6", ser_out, 1);
    end else begin
      check(ser_out == 1'b1, "R4", ser_out, 1);
    end
  endtask

  task automatic send_pre();
    for (int k = 7; k >= 0; k--) send_bit(PRE[k]);
  endtask

  task automatic send_len(input int l);
    for (int k = 23; k >= 0; k--) send_bit(l[k]);
  endtask

  task automatic send_data(input int n, input int seed);
    for (int k = 0; k < n; k++) send_bit(((k * seed) >> 1) & 1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R2: near-miss sharing the prefix, broken by one wrong bit
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    send_bit(0); send_bit(1); send_bit(0); send_bit(0);
    send_bit(1); send_bit(1); send_bit(1);
    send_pre(); send_len(40); send_data(40, 7); send_data(5, 3);
    check(load_done == 1'b1, "R6", load_done, 1);

    // R7: length below own share
    do_reset();
    send_pre(); send_len(10); send_data(10, 5); send_data(6, 1);
    // R6: zero length
    do_reset();
    send_pre(); send_len(0); send_data(4, 1);
    // R7: length equal to own share
    do_reset();
    send_pre(); send_len(OWN); send_data(OWN, 3); send_data(3, 1);
    // R5: one bit past own share
    do_reset();
    send_data(3, 1); send_pre(); send_len(OWN + 1); send_data(OWN + 1, 11);
    send_data(4, 3);
    // R3: longer stream, alternating data
    do_reset();
    send_pre(); send_len(64); send_data(64, 2); send_data(3, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule